// File: doc/BRIEF.md
# Paired Character FIFOs with DMA Ready Handshake

This block holds the characters that move between a serial engine and a CPU-side bus. It has two queues of equal depth. The receive queue is loaded by the serial engine and drained by the CPU, and every entry carries the received character together with its error flags. The transmit queue is loaded by the CPU and drained by the serial engine. Both queues report their occupancy. A push into a full receive queue is refused and sets a sticky overrun flag. A separate clear strobe for each queue empties that queue alone.

Two active-low outputs, `rxrdy_n` and `txrdy_n`, tell a DMA controller when to move data. In single-character mode the controller moves one character at a time. Receive-ready is shown whenever a character is waiting, and transmit-ready is shown only when the transmit queue is empty. In block mode the controller moves bursts. Receive-ready is shown once the receive occupancy reaches a programmable trigger level, or once a character timeout fires. Transmit-ready is withheld only while the transmit queue is completely full. The timeout catches a short tail of data that never reaches the trigger.

When queueing is switched off, each queue holds a single character, the timeout is held idle, and the ready outputs follow the single-character rules whatever the mode select says.

Top module: `fdma_fifo_pair`

## Requirements
- R1: Each queue holds up to DEPTH (default 16) entries and returns them in the order they were pushed. The head entry is presented on the read outputs before it is popped. A receive entry holds an 8-bit character and a 3-bit error field. A pop of an empty queue is ignored. A push and a pop in the same cycle on a full queue are both accepted.
- R2: `trig_sel` values 0, 1, 2 and 3 select receive trigger levels of 1, 4, 8 and 14 characters.
- R3: In block mode (`fifo_en`=1 and `dma_mode`=1), `rxrdy_n` is 0 while the receive level is at or above the trigger level or `rx_timeout` is 1. Otherwise it is 1.
- R4: In block mode, `txrdy_n` is 1 only while the transmit queue holds DEPTH entries. Otherwise it is 0.
- R5: In single-character mode (`dma_mode`=0, or `fifo_en`=0), `rxrdy_n` is 0 exactly while the receive level is nonzero, and `txrdy_n` is 0 exactly while the transmit level is zero.
- R6: With `fifo_en`=1, `rx_timeout` rises once the receive queue has held data for TIMEOUT_CHARS*CHAR_CYCLES consecutive clock cycles (default 4*16 = 64) with no receive push and no accepted receive pop. Any receive push or accepted receive pop clears it, and so does an empty queue.
- R7: A receive push into a full queue is dropped, leaving level and contents unchanged, and sets `rx_overrun`. The flag stays 1 until `rx_clear` or reset. A transmit push into a full queue is dropped without any flag.
- R8: `rx_clear` empties the receive queue, clears `rx_overrun` and leaves the transmit queue untouched. `tx_clear` empties the transmit queue and leaves the receive side untouched. A clear takes priority over a push in the same cycle.
- R9: With `fifo_en`=0, each queue accepts at most one entry, and a second receive push sets `rx_overrun`.
- R10: After reset both levels are 0, `rx_overrun` and `rx_timeout` are 0, `rxrdy_n` is 1 and `txrdy_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = full-depth queueing, 0 = single-entry holding |
| dma_mode | input | 1 | 0 = single-character ready rules, 1 = block ready rules |
| trig_sel | input | 2 | Receive trigger level select |
| rx_clear | input | 1 | Empty the receive queue and clear overrun |
| tx_clear | input | 1 | Empty the transmit queue |
| rx_push | input | 1 | Serial engine writes a received entry |
| rx_wdata | input | 8 | Received character |
| rx_werr | input | 3 | Error flags of the received character |
| rx_pop | input | 1 | CPU side removes the head receive entry |
| rx_rdata | output | 8 | Head receive character |
| rx_rerr | output | 3 | Error flags of the head receive character |
| rx_level | output | 5 | Receive occupancy |
| rx_overrun | output | 1 | Sticky: a receive push was dropped |
| rx_timeout | output | 1 | Receive character timeout |
| tx_push | input | 1 | CPU side writes a transmit character |
| tx_wdata | input | 8 | Transmit character |
| tx_pop | input | 1 | Serial engine takes the head transmit character |
| tx_rdata | output | 8 | Head transmit character |
| tx_level | output | 5 | Transmit occupancy |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| txrdy_n | output | 1 | Active-low transmit DMA request |

## Verification
Levels, head data, the overrun flag and both ready outputs change at the first rising edge that samples a strobe. The ready outputs are decoded without a register from the registered levels. `rx_timeout` rises at the 64th edge after the last receive activity. The bench therefore drives every strobe 2 ns after a rising edge and, after the following edge, reads the results at that same 2 ns offset. For the timeout it counts edges one by one, and checks the output low one edge before the limit and high on the limit edge.

// File: rtl/fdma_pkg.sv
package fdma_pkg;

    localparam int unsigned CHAR_W = 8;
    localparam int unsigned ERR_W  = 3;

    typedef enum logic {
        RDY_SINGLE = 1'b0,
        RDY_BLOCK  = 1'b1
    } rdy_mode_e;

    typedef struct packed {
        logic [CHAR_W-1:0] ch;
        logic [ERR_W-1:0]  err;
    } rx_entry_t;

    localparam int unsigned RX_ENTRY_W = $bits(rx_entry_t);

    // trigger ladder scaled from the queue depth: 1, depth/4, depth/2, depth-2
    function automatic int unsigned trig_level(input logic [1:0] sel,
                                               input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction

    function automatic rdy_mode_e eff_mode(input logic en, input logic sel);
        return (en && sel) ? RDY_BLOCK : RDY_SINGLE;
    endfunction

endpackage

// File: rtl/fdma_fifo.sv
module fdma_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          cap_one,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          pop_ok,
    output logic          push_drop
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cap;
    logic          push_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign cap       = cap_one ? CW'(1) : CW'(DEPTH);
    assign full      = (count >= cap);
    assign pop_ok    = pop && (count != '0);
    assign push_ok   = push && (!full || pop_ok);
    assign push_drop = push && !push_ok;
    assign rdata     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !clr) mem[wr_ptr] <= wdata;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R1

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (count == $past(count) || count == $past(count) + CW'(1)
                  || count == $past(count) - CW'(1))); // R1

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !clr) |=> $stable(count)); // R7

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0)); // R8

endmodule

// File: rtl/fdma_rx_timer.sv
module fdma_rx_timer #(
    parameter int unsigned LIMIT = 64,
    localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic has_data,
    input  logic activity,
    output logic timeout
);

    logic [TW-1:0] idle_cnt;

    always_ff @(posedge clk) begin
        if (rst || hold || activity || !has_data) begin
            idle_cnt <= '0;
        end else if (idle_cnt != TW'(LIMIT)) begin
            idle_cnt <= idle_cnt + TW'(1);
        end
    end

    assign timeout = (idle_cnt == TW'(LIMIT));

    AST_ACTIVITY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        activity |=> !timeout); // R6

    AST_TIMEOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (timeout && !activity && !hold && has_data) |=> timeout); // R6

endmodule

// File: rtl/fdma_rdy_gen.sv
module fdma_rdy_gen
    import fdma_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          fifo_en,
    input  logic          dma_mode,
    input  logic [1:0]    trig_sel,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] tx_count,
    input  logic          tx_full,
    input  logic          rx_timeout,
    output logic          rxrdy_n,
    output logic          txrdy_n
);

    rdy_mode_e     mode;
    logic [CW-1:0] trig;

    assign mode = eff_mode(fifo_en, dma_mode);
    assign trig = CW'(trig_level(trig_sel, DEPTH));

    always_comb begin
        unique case (mode)
            RDY_BLOCK: begin
                rxrdy_n = !((rx_count >= trig) || rx_timeout);
                txrdy_n = tx_full;
            end
            default: begin
                rxrdy_n = (rx_count == '0);
                txrdy_n = (tx_count != '0);
            end
        endcase
    end

endmodule

// File: rtl/fdma_fifo_pair.sv
module fdma_fifo_pair
    import fdma_pkg::*;
#(
    parameter int unsigned DEPTH         = 16,
    parameter int unsigned CHAR_CYCLES   = 16,
    parameter int unsigned TIMEOUT_CHARS = 4,
    localparam int unsigned CW           = $clog2(DEPTH + 1),
    localparam int unsigned LIMIT        = CHAR_CYCLES * TIMEOUT_CHARS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              dma_mode,
    input  logic [1:0]        trig_sel,
    input  logic              rx_clear,
    input  logic              tx_clear,
    input  logic              rx_push,
    input  logic [CHAR_W-1:0] rx_wdata,
    input  logic [ERR_W-1:0]  rx_werr,
    input  logic              rx_pop,
    output logic [CHAR_W-1:0] rx_rdata,
    output logic [ERR_W-1:0]  rx_rerr,
    output logic [CW-1:0]     rx_level,
    output logic              rx_overrun,
    output logic              rx_timeout,
    input  logic              tx_push,
    input  logic [CHAR_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [CHAR_W-1:0] tx_rdata,
    output logic [CW-1:0]     tx_level,
    output logic              rxrdy_n,
    output logic              txrdy_n
);

    rx_entry_t rx_in, rx_out;
    logic      rx_full, rx_pop_ok, rx_drop;
    logic      tx_full, tx_pop_ok, tx_drop;

    assign rx_in.ch  = rx_wdata;
    assign rx_in.err = rx_werr;

    fdma_fifo #(.W(RX_ENTRY_W), .DEPTH(DEPTH)) rx_q_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (rx_clear),
        .cap_one   (!fifo_en),
        .push      (rx_push),
        .wdata     (rx_in),
        .pop       (rx_pop),
        .rdata     (rx_out),
        .count     (rx_level),
        .full      (rx_full),
        .pop_ok    (rx_pop_ok),
        .push_drop (rx_drop)
    );

    assign rx_rdata = rx_out.ch;
    assign rx_rerr  = rx_out.err;

    fdma_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) tx_q_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (tx_clear),
        .cap_one   (!fifo_en),
        .push      (tx_push),
        .wdata     (tx_wdata),
        .pop       (tx_pop),
        .rdata     (tx_rdata),
        .count     (tx_level),
        .full      (tx_full),
        .pop_ok    (tx_pop_ok),
        .push_drop (tx_drop)
    );

    always_ff @(posedge clk) begin
        if (rst || rx_clear) rx_overrun <= 1'b0;
        else if (rx_drop)    rx_overrun <= 1'b1;
    end

    fdma_rx_timer #(.LIMIT(LIMIT)) rx_tmr_i (
        .clk      (clk),
        .rst      (rst),
        .hold     (rx_clear || !fifo_en),
        .has_data (rx_level != '0),
        .activity (rx_push || rx_pop_ok),
        .timeout  (rx_timeout)
    );

    fdma_rdy_gen #(.DEPTH(DEPTH)) rdy_i (
        .fifo_en    (fifo_en),
        .dma_mode   (dma_mode),
        .trig_sel   (trig_sel),
        .rx_count   (rx_level),
        .tx_count   (tx_level),
        .tx_full    (tx_full),
        .rx_timeout (rx_timeout),
        .rxrdy_n    (rxrdy_n),
        .txrdy_n    (txrdy_n)
    );

    AST_TXRDY_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && dma_mode && tx_level < CW'(DEPTH)) |-> !txrdy_n); // R4

    AST_RXRDY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (!(fifo_en && dma_mode) && rx_level != '0) |-> !rxrdy_n); // R5

    AST_RXRDY_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && dma_mode && rx_timeout) |-> !rxrdy_n); // R3

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun && !rx_clear) |=> rx_overrun); // R7

    AST_CLEAR_ISOLATE: assert property (@(posedge clk) disable iff (rst)
        (rx_clear && !tx_clear && !tx_push && !tx_pop) |=> $stable(tx_level)); // R8

    AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (rst)
        (!fifo_en && rx_level <= CW'(1) && !rx_clear) |=> (rx_level <= CW'(1))); // R9

endmodule

// File: tb/fdma_fifo_pair_tb_top.sv
module fdma_fifo_pair_tb_top;

    localparam int DEPTH = 16;
    localparam int CHARC = 16;
    localparam int TCH   = 4;
    localparam int LIMIT = CHARC * TCH;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fifo_en = 1'b1, dma_mode = 1'b0;
    logic [1:0] trig_sel = 2'd0;
    logic       rx_clear = 1'b0, tx_clear = 1'b0;
    logic       rx_push = 1'b0, rx_pop = 1'b0;
    logic [7:0] rx_wdata = '0;
    logic [2:0] rx_werr = '0;
    logic [7:0] rx_rdata;
    logic [2:0] rx_rerr;
    logic [4:0] rx_level;
    logic       rx_overrun, rx_timeout;
    logic       tx_push = 1'b0, tx_pop = 1'b0;
    logic [7:0] tx_wdata = '0;
    logic [7:0] tx_rdata;
    logic [4:0] tx_level;
    logic       rxrdy_n, txrdy_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    fdma_fifo_pair #(.DEPTH(DEPTH), .CHAR_CYCLES(CHARC), .TIMEOUT_CHARS(TCH)) dut_i (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .dma_mode(dma_mode),
        .trig_sel(trig_sel), .rx_clear(rx_clear), .tx_clear(tx_clear),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_werr(rx_werr),
        .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_rerr(rx_rerr),
        .rx_level(rx_level), .rx_overrun(rx_overrun), .rx_timeout(rx_timeout),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
        .tx_rdata(tx_rdata), .tx_level(tx_level),
        .rxrdy_n(rxrdy_n), .txrdy_n(txrdy_n)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int trig_of(input int ts);
        case (ts)
            0: return 1;
            1: return 4;
            2: return 8;
            default: return 14;
        endcase
    endfunction

    function automatic logic [7:0] rx_pat(input int k, input int ts, input int m);
        return 8'((k * 7 + ts * 29 + m * 3) & 255);
    endfunction

    function automatic logic [7:0] tx_pat(input int k, input int m);
        return 8'((k * 13 + m * 101 + 5) & 255);
    endfunction

    task automatic clear_rx();
        rx_clear = 1'b1; tick(); rx_clear = 1'b0;
    endtask

    task automatic clear_tx();
        tx_clear = 1'b1; tick(); tx_clear = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] d, input logic [2:0] e);
        rx_push = 1'b1; rx_wdata = d; rx_werr = e; tick(); rx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1; tick(); rx_pop = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] d);
        tx_push = 1'b1; tx_wdata = d; tick(); tx_push = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1; tick(); tx_pop = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        // R10 reset state
        check("R10 rx_level", int'(rx_level), 0);
        check("R10 tx_level", int'(tx_level), 0);
        check("R10 rxrdy_n", int'(rxrdy_n), 1);
        check("R10 txrdy_n", int'(txrdy_n), 0);
        check("R10 overrun", int'(rx_overrun), 0);
        check("R10 timeout", int'(rx_timeout), 0);

        // receive sweep: both ready modes, all trigger levels, every level
        for (int m = 0; m < 2; m++) begin
            for (int ts = 0; ts < 4; ts++) begin
                dma_mode = m[0];
                trig_sel = 2'(ts);
                clear_rx();
                check("R8 rx cleared", int'(rx_level), 0);
                check("R3 rxrdy_n at empty", int'(rxrdy_n), 1);
                for (int k = 1; k <= DEPTH; k++) begin
                    push_rx(rx_pat(k, ts, m), 3'(k % 8));
                    check("R1 rx level", int'(rx_level), k);
                    if (m == 1) check("R2 R3 block rxrdy_n", int'(rxrdy_n), (k >= trig_of(ts)) ? 0 : 1);
                    else        check("R5 single rxrdy_n", int'(rxrdy_n), 0);
                end
                check("R7 no overrun yet", int'(rx_overrun), 0);
                push_rx(8'hEE, 3'd7);
                check("R7 drop keeps level", int'(rx_level), DEPTH);
                check("R7 overrun set", int'(rx_overrun), 1);
                for (int k = 1; k <= DEPTH; k++) begin
                    check("R1 rx head data", int'(rx_rdata), int'(rx_pat(k, ts, m)));
                    check("R1 rx head err", int'(rx_rerr), k % 8);
                    pop_rx();
                    if (m == 1) check("R3 block rxrdy_n drain", int'(rxrdy_n), (DEPTH - k >= trig_of(ts)) ? 0 : 1);
                    else        check("R5 single rxrdy_n drain", int'(rxrdy_n), (DEPTH - k > 0) ? 0 : 1);
                end
                check("R7 overrun sticky", int'(rx_overrun), 1);
                pop_rx();
                check("R1 pop of empty ignored", int'(rx_level), 0);
            end
        end

        // transmit sweep
        for (int m = 0; m < 2; m++) begin
            dma_mode = m[0];
            clear_tx();
            check("R4 R5 txrdy_n at empty", int'(txrdy_n), 0);
            for (int k = 1; k <= DEPTH; k++) begin
                push_tx(tx_pat(k, m));
                check("R1 tx level", int'(tx_level), k);
                if (m == 1) check("R4 block txrdy_n", int'(txrdy_n), (k == DEPTH) ? 1 : 0);
                else        check("R5 single txrdy_n", int'(txrdy_n), 1);
            end
            push_tx(8'h55);
            check("R7 tx drop keeps level", int'(tx_level), DEPTH);
            for (int k = 1; k <= DEPTH; k++) begin
                check("R1 tx head data", int'(tx_rdata), int'(tx_pat(k, m)));
                pop_tx();
                if (m == 1) check("R4 block txrdy_n drain", int'(txrdy_n), 0);
                else        check("R5 single txrdy_n drain", int'(txrdy_n), (k == DEPTH) ? 0 : 1);
            end
        end

        // R6 timeout with trigger 14 so only the timeout can raise ready
        dma_mode = 1'b1; trig_sel = 2'd3;
        clear_rx();
        push_rx(8'h3C, 3'd2);
        repeat (LIMIT - 1) tick();
        check("R6 no timeout one cycle early", int'(rx_timeout), 0);
        check("R3 rxrdy_n before timeout", int'(rxrdy_n), 1);
        tick();
        check("R6 timeout at limit", int'(rx_timeout), 1);
        check("R3 rxrdy_n on timeout", int'(rxrdy_n), 0);
        push_rx(8'h3D, 3'd0);
        check("R6 push clears timeout", int'(rx_timeout), 0);
        repeat (LIMIT) tick();
        check("R6 timeout again", int'(rx_timeout), 1);
        pop_rx();
        check("R6 pop clears timeout", int'(rx_timeout), 0);
        check("R3 rxrdy_n after pop", int'(rxrdy_n), 1);
        pop_rx();
        repeat (LIMIT + 2) tick();
        check("R6 no timeout when empty", int'(rx_timeout), 0);

        // R1 push and pop together on a full queue
        clear_rx();
        for (int k = 1; k <= DEPTH; k++) push_rx(8'(k), 3'd1);
        rx_push = 1'b1; rx_pop = 1'b1; rx_wdata = 8'hA5; rx_werr = 3'd4;
        tick();
        rx_push = 1'b0; rx_pop = 1'b0;
        check("R1 full push+pop level", int'(rx_level), DEPTH);
        check("R1 full push+pop no overrun", int'(rx_overrun), 0);
        check("R1 full push+pop head", int'(rx_rdata), 2);

        // R8 independent clears and clear priority
        clear_tx();
        for (int k = 0; k < 5; k++) push_tx(8'(k + 1));
        push_rx(8'h01, 3'd0);
        check("R7 overrun before clear", int'(rx_overrun), 1);
        rx_clear = 1'b1; rx_push = 1'b1; tick(); rx_clear = 1'b0; rx_push = 1'b0;
        check("R8 rx clear beats push", int'(rx_level), 0);
        check("R8 rx clear drops overrun", int'(rx_overrun), 0);
        check("R8 tx untouched by rx_clear", int'(tx_level), 5);
        for (int k = 0; k < 3; k++) push_rx(8'(k), 3'd0);
        clear_tx();
        check("R8 tx cleared", int'(tx_level), 0);
        check("R8 rx untouched by tx_clear", int'(rx_level), 3);

        // R9 queueing disabled: single entry, single-character rules
        fifo_en = 1'b0; dma_mode = 1'b1; trig_sel = 2'd3;
        clear_rx(); clear_tx();
        push_rx(8'h77, 3'd5);
        check("R9 one rx entry", int'(rx_level), 1);
        check("R9 R5 rxrdy_n", int'(rxrdy_n), 0);
        push_rx(8'h78, 3'd6);
        check("R9 second rx dropped", int'(rx_level), 1);
        check("R9 overrun", int'(rx_overrun), 1);
        check("R9 kept first", int'(rx_rdata), 8'h77);
        push_tx(8'h10); push_tx(8'h11);
        check("R9 one tx entry", int'(tx_level), 1);
        check("R9 R5 txrdy_n", int'(txrdy_n), 1);
        repeat (LIMIT + 2) tick();
        check("R6 timer idle when disabled", int'(rx_timeout), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule